// File: doc/BRIEF.md
# GPIO Bank Register File with Masked-Write Aliases

This block holds the pin-control state for one GPIO bank made of several ports of eight pins each. Each port has three writable control registers (GPIO-mode enable, output enable and output value) and one read-only register that returns the synchronized pad levels. Software reaches them over a plain 32-bit register bus with a one-cycle registered read. The block drives the per-pin output value and output enable toward the pads and receives the raw pad levels.

Each writable register also has an alias address. A write to the alias carries a per-pin write mask next to the value byte, so a single bus write can change one pin atomically without a read-modify-write. A pin is driven only when both its mode-enable and output-enable bits are set. Pin multiplexing, interrupts and debounce are handled elsewhere.

Top module: `gpio_mw_bank`

## Requirements
- R1: After reset every control register is 0, `pad_oe` and `pad_out` are all 0, and `bus_rdata` is 0, so every pin starts as a non-driving input.
- R2: Register addresses are word-aligned: port p's registers are at p*4 plus a group offset (mode 0x00, output enable 0x10, output value 0x20, input 0x30). A plain write stores `bus_wdata[7:0]` and ignores the upper bits. A read asserted on one clock edge returns the value in `bus_rdata[7:0]` after that edge, with bits [31:8] at 0.
- R3: Adding 0x80 to the mode, output-enable or output-value address gives that register's masked alias. A write there updates only the pins whose bit in `bus_wdata[15:8]` is 1, loading them from `bus_wdata[7:0]`. Pins whose mask bit is 0 keep their value.
- R4: Pin n = port*8 + bit has `pad_oe[n]` = mode AND output enable, and `pad_out[n]` = output value when driving and 0 otherwise. The pads follow a register change one clock later.
- R5: `pad_in` passes through two flops. A level applied before clock edge k can first be read from the input register by a read sampled on edge k+2.
- R6: The input register is read-only. Writes to its plain address (0x30 + port*4) and to its alias (0xB0 + port*4) change no register.
- R7: A read of any masked alias address returns 0.
- R8: An address with any bit set outside [7] and [5:2] is unmapped: reads return 0 and writes change nothing. `bus_rdata` is 0 in any cycle that follows no read.
- R9: A write to one port changes no register of another port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, data returned the next cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data; [15:8] is the mask on alias writes |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels, asynchronous |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |

## Verification
The hardest behaviours to observe from the ports are the exact synchronizer latency and the fact that writes to the input register and its alias leave no trace. For the latency, the bench changes `pad_in` on a falling edge and reads the input register on consecutive reads. The first read must still return the old level and the next must return the new one. For the ignored writes, the bench writes all-ones to both input addresses and then reads back the input register and the neighbouring control registers. It also issues writes whose only error is an extra high address bit that would otherwise alias port 0. Pad drive gating is checked by raising output enable while mode is still off, and only then raising mode.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  // register group selected by the two address bits above the port field
  typedef enum logic [1:0] {
    GRP_MODE = 2'd0,
    GRP_OE   = 2'd1,
    GRP_OUT  = 2'd2,
    GRP_IN   = 2'd3
  } grp_e;

  localparam int NUM_WR_GRP = 3;
endpackage

// File: rtl/gpio_mw_addr_dec.sv
module gpio_mw_addr_dec
  import gpio_mw_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PORTS    = 4,
  parameter int PORT_W   = 2,
  parameter int MASK_BIT = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              masked,
  output grp_e              grp,
  output logic [PORT_W-1:0] port
);
  localparam int PORT_LSB = 2;
  localparam int GRP_LSB  = PORT_LSB + PORT_W;

  logic [ADDR_W-1:0] spare;

  always_comb begin
    spare = addr;
    spare[GRP_LSB+1:PORT_LSB] = '0;
    spare[MASK_BIT] = 1'b0;
    port   = addr[PORT_LSB +: PORT_W];
    grp    = grp_e'(addr[GRP_LSB +: 2]);
    masked = addr[MASK_BIT];
    hit    = (spare == '0) && (int'(port) < PORTS);
  end
endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
  import gpio_mw_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              masked,
  input  grp_e              grp,
  input  logic [2*PINS-1:0] wbits,
  output logic [PINS-1:0]   mode_q,
  output logic [PINS-1:0]   oe_q,
  output logic [PINS-1:0]   out_q
);
  logic [PINS-1:0] regs_q [NUM_WR_GRP];
  logic [PINS-1:0] wmask;
  logic [PINS-1:0] wval;

  assign wval  = wbits[PINS-1:0];
  assign wmask = wbits[2*PINS-1:PINS];

  for (genvar g = 0; g < NUM_WR_GRP; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (we && (grp == grp_e'(g))) begin
        if (masked) regs_q[g] <= (regs_q[g] & ~wmask) | (wval & wmask);
        else        regs_q[g] <= wval;
      end
    end
  end

  assign mode_q = regs_q[int'(GRP_MODE)];
  assign oe_q   = regs_q[int'(GRP_OE)];
  assign out_q  = regs_q[int'(GRP_OUT)];
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
  import gpio_mw_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int PORTS       = 4,
  parameter int PINS        = 8,
  parameter int MASK_BIT    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr_en,
  input  logic                   bus_rd_en,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [PORTS*PINS-1:0]  pad_in,
  output logic [PORTS*PINS-1:0]  pad_out,
  output logic [PORTS*PINS-1:0]  pad_oe
);
  localparam int NPIN   = PORTS * PINS;
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1;

  logic              dec_hit;
  logic              dec_masked;
  grp_e              dec_grp;
  logic [PORT_W-1:0] dec_port;

  gpio_mw_addr_dec #(
    .ADDR_W  (ADDR_W),
    .PORTS   (PORTS),
    .PORT_W  (PORT_W),
    .MASK_BIT(MASK_BIT)
  ) u_dec (
    .addr  (bus_addr),
    .hit   (dec_hit),
    .masked(dec_masked),
    .grp   (dec_grp),
    .port  (dec_port)
  );

  logic [NPIN-1:0] mode_v;
  logic [NPIN-1:0] oe_v;
  logic [NPIN-1:0] out_v;
  logic [NPIN-1:0] in_v;
  logic            wr_ok;

  // the input group has no storage behind a write
  assign wr_ok = bus_wr_en && dec_hit && (dec_grp != GRP_IN);

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_mw_port #(.PINS(PINS)) u_port (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_ok && (int'(dec_port) == p)),
      .masked(dec_masked),
      .grp   (dec_grp),
      .wbits (bus_wdata[2*PINS-1:0]),
      .mode_q(mode_v[p*PINS +: PINS]),
      .oe_q  (oe_v[p*PINS +: PINS]),
      .out_q (out_v[p*PINS +: PINS])
    );
  end

  gpio_mw_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pad_in),
    .q  (in_v)
  );

  // read path: one registered stage, zero when idle or unmapped
  logic [PINS-1:0] rd_sel;

  always_comb begin
    rd_sel = '0;
    if (dec_hit && !dec_masked) begin
      unique case (dec_grp)
        GRP_MODE: rd_sel = mode_v[int'(dec_port)*PINS +: PINS];
        GRP_OE:   rd_sel = oe_v[int'(dec_port)*PINS +: PINS];
        GRP_OUT:  rd_sel = out_v[int'(dec_port)*PINS +: PINS];
        GRP_IN:   rd_sel = in_v[int'(dec_port)*PINS +: PINS];
        default:  rd_sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= DATA_W'(rd_sel);
    else                bus_rdata <= '0;
  end

  // pad stage: drive only with mode and output enable both set
  logic [NPIN-1:0] drive;
  assign drive = mode_v & oe_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= drive;
      pad_out <= out_v & drive;
    end
  end
endmodule

// File: rtl/gpio_mw_bank_chk.sv
module gpio_mw_bank_chk #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NPIN     = 32,
  parameter int PINS     = 8,
  parameter int MASK_BIT = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe
);
  // R1: first cycle after reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

  // R2: read data never carries bits above the pin byte
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:PINS] == '0);

  // R4: a pin that is not enabled never shows a high output
  a_r4_drive_gate: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  // R7: alias reads return zero
  a_r7_alias_read_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd_en && bus_addr[MASK_BIT]) |-> bus_rdata == '0);

  // R8: no read, no data
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    $past(!bus_rd_en) |-> bus_rdata == '0);
endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NPIN    (PORTS*PINS),
  .PINS    (PINS),
  .MASK_BIT(MASK_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_rd_en(bus_rd_en),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/tb_gpio_mw_bank.sv
module tb_gpio_mw_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  gpio_mw_bank dut (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // vector table: kind 0 = write, 1 = read and compare
  localparam int NV = 25;
  localparam logic        V_KIND [NV] = '{
    0, 1, 0, 0, 1, 0, 1, 1, 0, 0, 1, 1, 0, 0, 1, 1, 0, 0, 1, 1, 0, 1, 0, 1, 1};
  localparam logic [11:0] V_ADDR [NV] = '{
    12'h000, 12'h000, 12'h010, 12'h020, 12'h020,   // R2 plain access
    12'h0A0, 12'h020, 12'h0A0,                     // R3 alias, R7 alias read
    12'h004, 12'h084, 12'h004, 12'h000,            // R3 mode alias, R9
    12'h030, 12'h0B0, 12'h030, 12'h010,            // R6 input read-only
    12'h100, 12'h040, 12'h100, 12'h000,            // R8 unmapped
    12'h008, 12'h008, 12'h0AC, 12'h02C, 12'h0B0};  // R2 upper bits, R3, R7
  localparam logic [31:0] V_DATA [NV] = '{
    32'h0000_00FF, 32'h0000_00FF, 32'h0000_000F, 32'h0000_00A5, 32'h0000_00A5,
    32'h0000_0302, 32'h0000_00A6, 32'h0000_0000,
    32'h0000_0033, 32'h0000_F0F0, 32'h0000_00F3, 32'h0000_00FF,
    32'h0000_00FF, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_000F,
    32'h0000_0077, 32'h0000_0077, 32'h0000_0000, 32'h0000_00FF,
    32'hFFFF_FF5A, 32'h0000_005A, 32'h0000_8080, 32'h0000_0080, 32'h0000_0000};
  localparam int V_REQ [NV] = '{
    2, 2, 2, 2, 2, 3, 3, 7, 3, 3, 3, 9, 6, 6, 6, 6, 8, 8, 8, 8, 2, 2, 3, 3, 7};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(posedge clk);
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=%08h exp=%08h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(12'h020, v); check("R1 out reg", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (V_KIND[i] == 1'b0) begin
        wr(V_ADDR[i], V_DATA[i]);
      end else begin
        rd(V_ADDR[i], v);
        check($sformatf("R%0d row%0d", V_REQ[i], i), v, V_DATA[i]);
      end
    end

    // R4: port0 mode FF, oe 0F, out A6; port3 out 80 but not enabled
    settle();
    check("R4 oe base", pad_oe, 32'h0000_000F);
    check("R4 out base", pad_out, 32'h0000_0006);
    wr(12'h09C, 32'h0000_8080);   // oe only on pin 31
    settle();
    check("R4 oe without mode", pad_oe, 32'h0000_000F);
    wr(12'h08C, 32'h0000_8080);   // mode on pin 31
    settle();
    check("R4 oe both set", pad_oe, 32'h8000_000F);
    check("R4 out both set", pad_out, 32'h8000_0006);
    wr(12'h0AC, 32'h0000_8000);   // drive pin 31 low
    settle();
    check("R4 drive low oe", pad_oe, 32'h8000_000F);
    check("R4 drive low out", pad_out, 32'h0000_0006);

    // R5: two-flop input path
    @(negedge clk) pad_in = 32'h1234_5678;
    rd(12'h030, v); check("R5 not yet visible", v, 32'h0);
    rd(12'h030, v); check("R5 port0", v, 32'h78);
    rd(12'h034, v); check("R5 port1", v, 32'h56);
    rd(12'h03C, v); check("R5 port3", v, 32'h12);
    // R6: input write and alias write leave the sample alone
    wr(12'h034, 32'h0000_00FF);
    wr(12'h0B4, 32'h0000_FF00);
    rd(12'h034, v); check("R6 input kept", v, 32'h56);

    // R1: reset in mid-run clears everything
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 mid pad_oe", pad_oe, 32'h0);
    check("R1 mid pad_out", pad_out, 32'h0);
    rd(12'h000, v); check("R1 mid mode", v, 32'h0);
    rd(12'h02C, v); check("R1 mid out3", v, 32'h0);

    finish_run();
  end
endmodule